// File: doc/BRIEF.md
# Codec Link Bring-Up Sequencer

This block is the control state machine that starts an AC97-style audio codec and keeps its mixer settings current. Out of reset it drives the codec's active-low reset pin low for a fixed number of clock cycles. It then enables frame sync and waits for the codec to report that it is ready. The ready flag is bit 15 of the slot-0 tag that the codec sends back; a neighbouring deserializer extracts that bit and presents it here as a raw level. If the flag does not appear within a timeout, the sequencer asserts the codec reset again and starts over.

Once the codec is ready, the sequencer issues a series of register writes to a frame serializer, one at a time. Each write is an address and data pair held under a request line until the serializer returns a one-cycle done pulse. The serializer sends one write per frame. The first write sets the PCM sample rate to 16'h0FA0. The next two carry the speaker and microphone volume and mute settings, built from switch inputs. After that the block sits in normal operation and writes a volume register again whenever its switch value differs from the value last written.

States:
- `ST_RST_HOLD`: codec reset low.
- `ST_WAIT_RDY`: reset released, sync running.
- `ST_WR_RATE`, `ST_WR_SPK`, `ST_WR_MIC`: a write is requested.
- `ST_DISPATCH`: a one-cycle choice made after each write.
- `ST_RUN`: normal operation.

Transitions:
- `ST_RST_HOLD` goes to `ST_WAIT_RDY` when the hold count expires.
- `ST_WAIT_RDY` goes to `ST_WR_RATE` on synchronized ready, or back to `ST_RST_HOLD` on timeout.
- Each write state goes to `ST_DISPATCH` on done.
- `ST_DISPATCH` and `ST_RUN` go to `ST_WR_SPK` if the speaker setting is pending. Otherwise they go to `ST_WR_MIC` if the microphone setting is pending. Otherwise they go to `ST_RUN`.

Top module: `codec_bringup_seq`

## Requirements
- R1: After `rst_n` is released, `codec_rst_n` stays low for exactly RST_HOLD_CYC clock cycles, then goes high. While it is low, `sync_run` and `wr_req` are low.
- R2: `wr_req` is never raised before `codec_tag_rdy` has been high. The ready input passes through a SYNC_STAGES-flop synchronizer before it is used.
- R3: If synchronized ready is not seen within READY_TIMEOUT cycles after `codec_rst_n` rises, `codec_rst_n` falls again and a full RST_HOLD_CYC hold restarts.
- R4: The first write after ready has address 7'h2C and data 16'h0FA0.
- R5: Initialization writes go in this order: rate (7'h2C), speaker (7'h02), microphone (7'h0E). Only after all three does `link_up` rise.
- R6: Handshake rules:
  - Once `wr_req` is raised, it stays high with stable `wr_addr` and `wr_data` until the cycle in which `wr_done` is high.
  - `wr_req` is low in the following cycle.
  - A `wr_done` pulse while no request is open has no effect.
- R7: The speaker word is {mute, 2'b00, att[4:0], 3'b000, att[4:0]}. Bit 15 is the mute, and the attenuation sits in both the left field (bits 12:8) and the right field (bits 4:0).
- R8: The microphone word is {mute, 10'b0, att[4:0]}. Bit 15 is the mute and bits 4:0 are the attenuation.
- R9: In normal operation, a change to one group of switches causes exactly one write, to that group's register only. If both groups change, the speaker write comes first. Rewriting a switch with the same value causes no write.
- R10: `link_up` is high only in normal operation with no write outstanding. It never rises before a write has completed.
- R11: A switch change made while a write is in flight is not lost. Once the block settles, the last word written to each volume register matches the current switches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| codec_tag_rdy | input | 1 | Codec-ready bit from the incoming slot-0 tag (asynchronous) |
| spk_att | input | 5 | Speaker attenuation switches |
| spk_mute | input | 1 | Speaker mute switch |
| mic_att | input | 5 | Microphone attenuation switches |
| mic_mute | input | 1 | Microphone mute switch |
| wr_done | input | 1 | One-cycle pulse from the serializer when the current write has been sent |
| codec_rst_n | output | 1 | Active-low reset to the codec |
| sync_run | output | 1 | Enables frame sync generation |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 7 | Codec register address of the current write |
| wr_data | output | 16 | Data word of the current write |
| link_up | output | 1 | Initialization finished, no write outstanding |

## Verification
The assertions assume the serializer model's behaviour:
- It raises `wr_done` for exactly one cycle.
- It raises `wr_done` only while a request is open.
- It never raises `wr_done` in the same cycle that the request first appears unless it has sampled that request.

The bench's serializer model waits a random 0 to 6 cycles after seeing the request before pulsing done. Only one directed test breaks the open-request assumption: it injects a stray pulse during normal operation, and that test is checked at the ports.

The assertions also take the ready input as a level that stays high once it rises. The stimulus raises it once during the second reset hold and never drops it. Switch changes are applied on the falling clock edge and are otherwise unconstrained in timing, so some of them land while a write is in flight.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] REG_RATE = 7'h2C;
    localparam logic [ADDR_W-1:0] REG_SPK  = 7'h02;
    localparam logic [ADDR_W-1:0] REG_MIC  = 7'h0E;
    localparam logic [DATA_W-1:0] RATE_WORD = 16'h0FA0;

    typedef enum logic [2:0] {
        ST_RST_HOLD,
        ST_WAIT_RDY,
        ST_WR_RATE,
        ST_DISPATCH,
        ST_WR_SPK,
        ST_WR_MIC,
        ST_RUN
    } seq_state_t;

endpackage

// File: rtl/seq_bit_sync.sv
module seq_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/vol_word_fmt.sv
module vol_word_fmt #(
    parameter int ATT_W  = 5,
    parameter bit STEREO = 1'b1
) (
    input  logic [ATT_W-1:0] att,
    input  logic             mute,
    output logic [15:0]      word
);
    generate
        if (STEREO) begin : g_stereo
            always_comb begin
                word            = '0;
                word[15]        = mute;
                word[8+:ATT_W]  = att;
                word[0+:ATT_W]  = att;
            end
        end else begin : g_mono
            always_comb begin
                word            = '0;
                word[15]        = mute;
                word[0+:ATT_W]  = att;
            end
        end
    endgenerate
endmodule

// File: rtl/codec_bringup_seq.sv
module codec_bringup_seq
    import codec_seq_pkg::*;
#(
    parameter int RST_HOLD_CYC  = 256,
    parameter int READY_TIMEOUT = 4096,
    parameter int ATT_W         = 5,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              codec_tag_rdy,
    input  logic [ATT_W-1:0]  spk_att,
    input  logic              spk_mute,
    input  logic [ATT_W-1:0]  mic_att,
    input  logic              mic_mute,
    input  logic              wr_done,
    output logic              codec_rst_n,
    output logic              sync_run,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              link_up
);
    localparam int CNT_MAX = (RST_HOLD_CYC > READY_TIMEOUT) ? RST_HOLD_CYC : READY_TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(READY_TIMEOUT - 1);
    localparam int SW_W = ATT_W + 1;

    seq_state_t state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic              rdy_s;
    logic [SW_W-1:0]   spk_q, mic_q, spk_sent, mic_sent, cmd_raw;
    logic              spk_ok, mic_ok;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic [DATA_W-1:0] spk_word, mic_word;
    logic              spk_pend, mic_pend;

    seq_bit_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (codec_tag_rdy),
        .q     (rdy_s)
    );

    vol_word_fmt #(.ATT_W(ATT_W), .STEREO(1'b1)) u_spk_fmt (
        .att  (spk_q[ATT_W-1:0]),
        .mute (spk_q[ATT_W]),
        .word (spk_word)
    );

    vol_word_fmt #(.ATT_W(ATT_W), .STEREO(1'b0)) u_mic_fmt (
        .att  (mic_q[ATT_W-1:0]),
        .mute (mic_q[ATT_W]),
        .word (mic_word)
    );

    assign spk_pend = !spk_ok || (spk_q != spk_sent);
    assign mic_pend = !mic_ok || (mic_q != mic_sent);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RST_HOLD;
        else        state <= state_n;
    end

    // Next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_RST_HOLD: if (cnt == HOLD_LAST) state_n = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (rdy_s)                state_n = ST_WR_RATE;
                else if (cnt == TO_LAST)  state_n = ST_RST_HOLD;
            end
            ST_WR_RATE, ST_WR_SPK, ST_WR_MIC: if (wr_done) state_n = ST_DISPATCH;
            ST_DISPATCH, ST_RUN: begin
                if (spk_pend)      state_n = ST_WR_SPK;
                else if (mic_pend) state_n = ST_WR_MIC;
                else               state_n = ST_RUN;
            end
            default: state_n = ST_RST_HOLD;
        endcase
    end

    // Counter, switch capture, command latch and sent-value tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            spk_q    <= '0;
            mic_q    <= '0;
            spk_sent <= '0;
            mic_sent <= '0;
            spk_ok   <= 1'b0;
            mic_ok   <= 1'b0;
            cmd_raw  <= '0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            spk_q <= {spk_mute, spk_att};
            mic_q <= {mic_mute, mic_att};

            if (state_n != state)
                cnt <= '0;
            else if (state == ST_RST_HOLD || state == ST_WAIT_RDY)
                cnt <= cnt + 1'b1;

            if (state_n != state) begin
                unique case (state_n)
                    ST_WR_RATE: begin
                        cmd_addr <= REG_RATE;
                        cmd_data <= RATE_WORD;
                    end
                    ST_WR_SPK: begin
                        cmd_addr <= REG_SPK;
                        cmd_data <= spk_word;
                        cmd_raw  <= spk_q;
                    end
                    ST_WR_MIC: begin
                        cmd_addr <= REG_MIC;
                        cmd_data <= mic_word;
                        cmd_raw  <= mic_q;
                    end
                    ST_RST_HOLD: begin
                        spk_ok <= 1'b0;
                        mic_ok <= 1'b0;
                    end
                    default: ;
                endcase
            end

            if (state == ST_WR_SPK && wr_done) begin
                spk_sent <= cmd_raw;
                spk_ok   <= 1'b1;
            end
            if (state == ST_WR_MIC && wr_done) begin
                mic_sent <= cmd_raw;
                mic_ok   <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        codec_rst_n = (state != ST_RST_HOLD);
        sync_run    = (state != ST_RST_HOLD);
        wr_req      = (state == ST_WR_RATE) || (state == ST_WR_SPK) || (state == ST_WR_MIC);
        link_up     = (state == ST_RUN);
        wr_addr     = cmd_addr;
        wr_data     = cmd_data;
    end
endmodule

// File: rtl/codec_seq_chk.sv
module codec_seq_chk #(
    parameter int RST_HOLD_CYC = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        codec_tag_rdy,
    input logic        wr_done,
    input logic        codec_rst_n,
    input logic        wr_req,
    input logic [6:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic        link_up
);
    localparam int LW = $clog2(RST_HOLD_CYC + 2);

    logic [LW-1:0] low_cnt;
    logic          seen_rdy;
    logic          any_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            seen_rdy <= 1'b0;
            any_done <= 1'b0;
        end else begin
            if (codec_rst_n)                         low_cnt <= '0;
            else if (low_cnt < LW'(RST_HOLD_CYC + 1)) low_cnt <= low_cnt + 1'b1;
            if (codec_tag_rdy)      seen_rdy <= 1'b1;
            if (wr_req && wr_done)  any_done <= 1'b1;
        end
    end

    assert_hold_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(codec_rst_n) |-> (low_cnt >= LW'(RST_HOLD_CYC)));

    assert_wait_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> seen_rdy);

    assert_rate_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !any_done) |-> (wr_addr == 7'h2C && wr_data == 16'h0FA0));

    assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_done) |=> !wr_req);

    assert_link_after_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> any_done);
endmodule

bind codec_bringup_seq codec_seq_chk #(.RST_HOLD_CYC(RST_HOLD_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .codec_tag_rdy (codec_tag_rdy),
    .wr_done       (wr_done),
    .codec_rst_n   (codec_rst_n),
    .wr_req        (wr_req),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .link_up       (link_up)
);

// File: tb/codec_bringup_seq_tb.sv
`timescale 1ns/1ps
module codec_bringup_seq_tb;
    localparam int HOLD = 20;
    localparam int TO   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tag_rdy = 1'b0;
    logic [5:0] spk_v = 6'h0A;
    logic [5:0] mic_v = 6'h33;
    logic done_srv = 1'b0;
    logic done_stray = 1'b0;
    logic wr_done;
    logic codec_rst_n, sync_run, wr_req, link_up;
    logic [6:0] wr_addr;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    int r2_viol = 0;
    bit rdy_ever = 0;
    bit finished = 0;
    logic [6:0]  log_a[$];
    logic [15:0] log_d[$];

    always #2 clk = ~clk;
    assign wr_done = done_srv | done_stray;

    codec_bringup_seq #(.RST_HOLD_CYC(HOLD), .READY_TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .codec_tag_rdy(tag_rdy),
        .spk_att(spk_v[4:0]), .spk_mute(spk_v[5]),
        .mic_att(mic_v[4:0]), .mic_mute(mic_v[5]),
        .wr_done(wr_done), .codec_rst_n(codec_rst_n), .sync_run(sync_run),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .link_up(link_up)
    );

    function automatic logic [15:0] spk_w(logic [5:0] v);
        return {v[5], 2'b00, v[4:0], 3'b000, v[4:0]};
    endfunction
    function automatic logic [15:0] mic_w(logic [5:0] v);
        return {v[5], 10'b0, v[4:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_link();
        int k = 0;
        while (!link_up && k < 500) begin
            @(negedge clk);
            k++;
        end
    endtask

    // serializer model
    initial begin
        logic [6:0]  a;
        logic [15:0] d;
        int dly;
        forever begin
            @(negedge clk);
            if (wr_req) begin
                a = wr_addr;
                d = wr_data;
                log_a.push_back(a);
                log_d.push_back(d);
                dly = $urandom_range(0, 6);
                for (int i = 0; i < dly; i++) begin
                    @(negedge clk);
                    chk(wr_req && wr_addr == a && wr_data == d, "R6", "request held stable",
                        {wr_req, wr_addr, wr_data}, {1'b1, a, d});
                end
                done_srv = 1'b1;
                @(negedge clk);
                done_srv = 1'b0;
                chk(!wr_req, "R6", "request dropped after done", wr_req, 0);
            end
        end
    end

    // R2 monitor
    always @(negedge clk) if (rst_n && wr_req && !rdy_ever) r2_viol++;

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int n, base, mode, exp_n, last_s, last_m;
        bit mid;
        logic [5:0] ns, nm;
        logic [6:0]  ea[$];
        logic [15:0] ed[$];

        void'($urandom(32'd7351));
        repeat (5) @(negedge clk);
        chk(!codec_rst_n && !sync_run && !wr_req && !link_up, "R1", "reset state",
            {codec_rst_n, sync_run, wr_req, link_up}, 0);

        rst_n = 1'b1;
        n = 0;
        while (!codec_rst_n && n < 1000) begin
            @(negedge clk);
            n++;
            if (!codec_rst_n && (sync_run || wr_req)) chk(0, "R1", "outputs quiet in hold", 1, 0);
        end
        chk(n == HOLD, "R1", "first hold length", n, HOLD);
        chk(sync_run, "R1", "sync runs after hold", sync_run, 1);

        n = 0;
        while (codec_rst_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == TO, "R3", "ready timeout length", n, TO);

        tag_rdy = 1'b1;
        rdy_ever = 1'b1;
        n = 0;
        while (!codec_rst_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == HOLD, "R3", "hold restarted in full", n, HOLD);

        wait_link();
        chk(link_up, "R5", "link up after init", link_up, 1);
        chk(log_a.size() == 3, "R5", "init write count", log_a.size(), 3);
        if (log_a.size() >= 3) begin
            chk(log_a[0] == 7'h2C && log_d[0] == 16'h0FA0, "R4", "rate write",
                {log_a[0], log_d[0]}, {7'h2C, 16'h0FA0});
            chk(log_a[1] == 7'h02 && log_d[1] == spk_w(6'h0A), "R7", "init speaker write",
                {log_a[1], log_d[1]}, {7'h02, spk_w(6'h0A)});
            chk(log_a[2] == 7'h0E && log_d[2] == mic_w(6'h33), "R8", "init mic write",
                {log_a[2], log_d[2]}, {7'h0E, mic_w(6'h33)});
        end

        // stray done pulse during normal operation
        base = log_a.size();
        @(negedge clk);
        done_stray = 1'b1;
        @(negedge clk);
        done_stray = 1'b0;
        repeat (5) @(negedge clk);
        chk(link_up && !wr_req && log_a.size() == base, "R6", "stray done ignored",
            log_a.size(), base);

        // directed: speaker mute toggle only
        base = log_a.size();
        spk_v = spk_v ^ 6'h20;
        repeat (3) @(negedge clk);
        wait_link();
        chk(log_a.size() == base + 1, "R9", "mute toggle write count", log_a.size(), base + 1);
        if (log_a.size() == base + 1)
            chk(log_a[base] == 7'h02 && log_d[base] == spk_w(spk_v), "R7", "mute bit 15 word",
                log_d[base], spk_w(spk_v));

        // directed: same value rewritten
        base = log_a.size();
        mic_v = mic_v;
        spk_v = spk_v;
        repeat (8) @(negedge clk);
        chk(log_a.size() == base && link_up, "R10", "unchanged switches idle", log_a.size(), base);

        // random switch changes
        for (int it = 0; it < 40; it++) begin
            mode = $urandom_range(0, 3);
            mid  = (mode != 0) && ($urandom_range(0, 3) == 0);
            base = log_a.size();
            ns = spk_v;
            nm = mic_v;
            if (mode == 1 || mode == 3) ns = spk_v ^ 6'($urandom_range(1, 63));
            if (mode == 2 || mode == 3) nm = mic_v ^ 6'($urandom_range(1, 63));
            spk_v = ns;
            mic_v = nm;
            if (mid) begin
                repeat (2) @(negedge clk);
                spk_v = spk_v ^ 6'($urandom_range(1, 63));
            end
            repeat (3) @(negedge clk);
            wait_link();
            chk(link_up, "R10", "settled to normal operation", link_up, 1);
            if (!mid) begin
                ea.delete();
                ed.delete();
                if (mode == 1 || mode == 3) begin ea.push_back(7'h02); ed.push_back(spk_w(ns)); end
                if (mode == 2 || mode == 3) begin ea.push_back(7'h0E); ed.push_back(mic_w(nm)); end
                exp_n = ea.size();
                chk(log_a.size() == base + exp_n, "R9", "writes per change",
                    log_a.size() - base, exp_n);
                if (log_a.size() == base + exp_n)
                    for (int j = 0; j < exp_n; j++)
                        chk(log_a[base+j] == ea[j] && log_d[base+j] == ed[j], "R9",
                            "write order and word", {log_a[base+j], log_d[base+j]}, {ea[j], ed[j]});
            end else begin
                last_s = -1;
                last_m = -1;
                for (int j = 0; j < log_a.size(); j++) begin
                    if (log_a[j] == 7'h02) last_s = j;
                    if (log_a[j] == 7'h0E) last_m = j;
                end
                chk(last_s >= 0 && log_d[last_s] == spk_w(spk_v), "R11", "last speaker word",
                    (last_s >= 0) ? log_d[last_s] : 0, spk_w(spk_v));
                chk(last_m >= 0 && log_d[last_m] == mic_w(mic_v), "R11", "last mic word",
                    (last_m >= 0) ? log_d[last_m] : 0, mic_w(mic_v));
            end
        end

        chk(r2_viol == 0, "R2", "no request before ready", r2_viol, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule